// File: doc/BRIEF.md
# Capture/Compare Event Timer

This block is a 32-bit counter peripheral behind a small register port. A clock-source selector (system clock, system clock divided by a slow ratio, or an external input pin) feeds a programmable prescaler, and every prescaler terminal tick advances the counter by one or by a wide step. The counter is compared with a reference value to produce periodic reference events, and an input pin can capture the running count on a chosen edge.

Events set sticky flags. The flags drive an interrupt request through per-flag enables, and drive a DMA request when DMA is enabled. Software clears a flag by writing one to it. A DMA acknowledge pulse clears both flags at once. A one-cycle reference pulse output marks every reference event. Typical use: set the reference to `T*f/(div*(ps+1)) - 1`, turn on restart mode, and service the interrupt once per period.

Top module: `evt_timer`

## Requirements
- R1: After reset, every register reads zero. `irqReq`, `dmaReq` and `refPulse` are low, and addresses 6 and 7 read zero. Register addresses: 0 mode, 1 extended mode, 2 event, 3 reference, 4 capture, 5 counter.
- R2: Mode bits [2:1] select the count source: 00 none (the counter holds), 01 system clock, 10 system clock divided by 16, 11 rising edges of `extClkIn` after a two-flop synchronizer.
- R3: Mode bits [15:8] hold a prescale value p. The source is divided by p+1. In restart mode the reference event period is div*(p+1)*(ref+1) clock cycles.
- R4: A reference event occurs on a counter tick while the counter equals the reference. At that event `refPulse` is high for that cycle. With mode bit 3 set, the counter then goes to zero. With bit 3 clear, it keeps counting past the reference.
- R5: Extended-mode bit 0 chooses the counter step: 0 adds 1, 1 adds 65,537. Addition is modulo 2^32.
- R6: Mode bit 0 enables the timer. While it is clear, the counter and prescaler hold their values.
- R7: A write of any value to the counter address clears the counter to zero. Reading the counter does not change it.
- R8: Mode bits [7:6] choose the capture edge of `capIn`: 00 off, 01 rising, 10 falling, 11 both. A capture loads the current count into the capture register and sets the capture flag. Writes to the capture register are ignored.
- R9: Event register bit 1 is the reference flag and bit 0 is the capture flag. Each flag is set by its event whatever the enables are. Writing 1 to a bit clears it, and writing 0 leaves it unchanged. A new event in the same cycle wins over a clear.
- R10: `irqReq` is high while (reference flag and mode bit 4) or (capture flag and mode bit 5).
- R11: Extended-mode bit 1 enables DMA. `dmaReq` is high while DMA is enabled and any flag is set. A `dmaAck` pulse clears both flags only while DMA is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address for reads and writes |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` (combinational) |
| extClkIn | input | 1 | External count source |
| capIn | input | 1 | Capture input |
| dmaAck | input | 1 | DMA acknowledge pulse |
| irqReq | output | 1 | Interrupt request |
| dmaReq | output | 1 | DMA request |
| refPulse | output | 1 | One-cycle reference event marker |

## Verification
The bench uses the default parameters: a 32-bit counter, an 8-bit prescaler, a slow divide of 16 and two synchronizer stages. The narrow prescaler lets the full prescale range run in a few hundred cycles. It also lets random periods over both internal sources be measured exactly between consecutive reference pulses. With 16-bit halves, the wide step gives counts that differ clearly from the unit step after only a handful of ticks.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam logic [2:0] A_MODE  = 3'd0;
  localparam logic [2:0] A_XMODE = 3'd1;
  localparam logic [2:0] A_EVENT = 3'd2;
  localparam logic [2:0] A_REF   = 3'd3;
  localparam logic [2:0] A_CAPT  = 3'd4;
  localparam logic [2:0] A_COUNT = 3'd5;

  localparam logic [1:0] SRC_OFF  = 2'b00;
  localparam logic [1:0] SRC_FAST = 2'b01;
  localparam logic [1:0] SRC_SLOW = 2'b10;
  localparam logic [1:0] SRC_EXT  = 2'b11;

  typedef struct packed {
    logic tick;
    logic restart;
    logic wideStep;
    logic clearCnt;
    logic loadRef;
    logic capture;
  } dpStrobe_t;
endpackage

// File: rtl/evt_timer_sync.sv
module evt_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] shReg;

  always_ff @(posedge clk) begin
    if (!rstN) shReg <= '0;
    else       shReg <= {shReg[STAGES-1:0], din};
  end

  assign rise = shReg[STAGES-1] & ~shReg[STAGES];
  assign fall = ~shReg[STAGES-1] & shReg[STAGES];
endmodule

// File: rtl/evt_timer_ctl.sv
module evt_timer_ctl
  import evt_timer_pkg::*;
#(
  parameter int PS_W        = 8,
  parameter int SLOW_DIV    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int MODE_W     = 8 + PS_W,
  localparam int DIV_W      = $clog2(SLOW_DIV)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [MODE_W-1:0] wrData,
  input  logic              extClkIn,
  input  logic              capIn,
  input  logic              dmaAck,
  input  logic              refEvt,
  output dpStrobe_t         strb,
  output logic [MODE_W-1:0] modeReg,
  output logic [1:0]        xmodeReg,
  output logic [1:0]        flags,
  output logic              irqReq,
  output logic              dmaReq
);
  logic             enable, restart, refIrqEn, capIrqEn, wideStep, dmaEn;
  logic [1:0]       srcSel, capEdge;
  logic [PS_W-1:0]  psVal, psCnt;
  logic [DIV_W-1:0] divCnt;
  logic             slowTick, srcTick, psTerm, cntTick;
  logic             extRise, extFall, capRise, capFall, capStrobe;
  logic [1:0]       swClr, ackClr;

  assign enable   = modeReg[0];
  assign srcSel   = modeReg[2:1];
  assign restart  = modeReg[3];
  assign refIrqEn = modeReg[4];
  assign capIrqEn = modeReg[5];
  assign capEdge  = modeReg[7:6];
  assign psVal    = modeReg[MODE_W-1:8];
  assign wideStep = xmodeReg[0];
  assign dmaEn    = xmodeReg[1];

  evt_timer_sync #(.STAGES(SYNC_STAGES)) extSync_i (
    .clk(clk), .rstN(rstN), .din(extClkIn), .rise(extRise), .fall(extFall));
  evt_timer_sync #(.STAGES(SYNC_STAGES)) capSync_i (
    .clk(clk), .rstN(rstN), .din(capIn), .rise(capRise), .fall(capFall));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= '0;
      xmodeReg <= '0;
    end else if (wrEn) begin
      if (addr == A_MODE)  modeReg  <= wrData;
      if (addr == A_XMODE) xmodeReg <= wrData[1:0];
    end
  end

  // slow source divider runs only while selected and enabled
  assign slowTick = (divCnt == DIV_W'(SLOW_DIV - 1));
  always_ff @(posedge clk) begin
    if (!rstN) divCnt <= '0;
    else if (enable && srcSel == SRC_SLOW) divCnt <= slowTick ? '0 : divCnt + 1'b1;
  end

  always_comb begin
    unique case (srcSel)
      SRC_FAST: srcTick = enable;
      SRC_SLOW: srcTick = enable & slowTick;
      SRC_EXT:  srcTick = enable & extRise;
      default:  srcTick = 1'b0;
    endcase
  end

  // terminal compare uses >= so a lowered prescale never strands the count
  assign psTerm  = (psCnt >= psVal);
  assign cntTick = srcTick & psTerm;
  always_ff @(posedge clk) begin
    if (!rstN)        psCnt <= '0;
    else if (srcTick) psCnt <= psTerm ? '0 : psCnt + 1'b1;
  end

  assign capStrobe = (capEdge[0] & capRise) | (capEdge[1] & capFall);

  assign swClr  = (wrEn && addr == A_EVENT) ? wrData[1:0] : 2'b00;
  assign ackClr = (dmaAck && dmaEn) ? 2'b11 : 2'b00;
  always_ff @(posedge clk) begin
    if (!rstN) flags <= '0;
    else       flags <= (flags & ~swClr & ~ackClr) | {refEvt, capStrobe};
  end

  assign irqReq = (flags[1] & refIrqEn) | (flags[0] & capIrqEn);
  assign dmaReq = dmaEn & (|flags);

  always_comb begin
    strb          = '0;
    strb.tick     = cntTick;
    strb.restart  = restart;
    strb.wideStep = wideStep;
    strb.clearCnt = wrEn && (addr == A_COUNT);
    strb.loadRef  = wrEn && (addr == A_REF);
    strb.capture  = capStrobe;
  end

  // R9
  ref_flag_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flags[1]) |-> $past(refEvt));
  // R9
  w1c_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_EVENT && wrData[1] && !refEvt) |=> !flags[1]);
  // R11
  dma_ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dmaAck && dmaEn && !refEvt && !capStrobe) |=> (flags == 2'b00));
  // R3
  ps_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcTick && psTerm) |=> (psCnt == '0));
  // R6
  ps_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(psCnt));

  logic unusedFall;
  assign unusedFall = extFall;
endmodule

// File: rtl/evt_timer_dp.sv
module evt_timer_dp
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] refVal,
  output logic [CNT_W-1:0] capVal,
  output logic             refEvt
);
  localparam logic [CNT_W-1:0] UNIT_STEP = CNT_W'(1);
  localparam logic [CNT_W-1:0] WIDE_STEP = CNT_W'(1) | (CNT_W'(1) << (CNT_W / 2));

  logic [CNT_W-1:0] step;
  logic             match;

  assign step   = strb.wideStep ? WIDE_STEP : UNIT_STEP;
  assign match  = (cnt == refVal);
  assign refEvt = strb.tick & match;

  always_ff @(posedge clk) begin
    if (!rstN)                       cnt <= '0;
    else if (strb.clearCnt)          cnt <= '0;
    else if (strb.tick)              cnt <= (match && strb.restart) ? '0 : cnt + step;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             refVal <= '0;
    else if (strb.loadRef) refVal <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             capVal <= '0;
    else if (strb.capture) capVal <= cnt;
  end

  // R8
  capture_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> (capVal == $past(cnt)));
  // R7
  count_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearCnt |=> (cnt == '0));
  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.clearCnt) |=> $stable(cnt));
  // R4
  restart_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && strb.restart && match && !strb.clearCnt) |=> (cnt == '0));
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PS_W        = 8,
  parameter int SLOW_DIV    = 16,
  parameter int SYNC_STAGES = 2,
  localparam int MODE_W     = 8 + PS_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wrData,
  output logic [CNT_W-1:0] rdData,
  input  logic             extClkIn,
  input  logic             capIn,
  input  logic             dmaAck,
  output logic             irqReq,
  output logic             dmaReq,
  output logic             refPulse
);
  dpStrobe_t         strb;
  logic [MODE_W-1:0] modeReg;
  logic [1:0]        xmodeReg, flags;
  logic [CNT_W-1:0]  cnt, refVal, capVal;
  logic              refEvt;

  evt_timer_ctl #(.PS_W(PS_W), .SLOW_DIV(SLOW_DIV), .SYNC_STAGES(SYNC_STAGES)) ctl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData[MODE_W-1:0]),
    .extClkIn(extClkIn), .capIn(capIn), .dmaAck(dmaAck), .refEvt(refEvt),
    .strb(strb), .modeReg(modeReg), .xmodeReg(xmodeReg), .flags(flags),
    .irqReq(irqReq), .dmaReq(dmaReq));

  evt_timer_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .cnt(cnt), .refVal(refVal), .capVal(capVal), .refEvt(refEvt));

  assign refPulse = refEvt;

  always_comb begin
    unique case (addr)
      A_MODE:  rdData = CNT_W'(modeReg);
      A_XMODE: rdData = CNT_W'(xmodeReg);
      A_EVENT: rdData = CNT_W'(flags);
      A_REF:   rdData = refVal;
      A_CAPT:  rdData = capVal;
      A_COUNT: rdData = cnt;
      default: rdData = '0;
    endcase
  end
endmodule

// File: tb/evt_timer_tb_top.sv
module evt_timer_tb_top;
  import evt_timer_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        extClkIn = 1'b0, capIn = 1'b0, dmaAck = 1'b0;
  logic        irqReq, dmaReq, refPulse;

  int nChecks = 0;
  int nFail   = 0;

  always #10 clk = ~clk;

  evt_timer dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .extClkIn(extClkIn), .capIn(capIn), .dmaAck(dmaAck),
    .irqReq(irqReq), .dmaReq(dmaReq), .refPulse(refPulse));

  function automatic logic [31:0] modeWord(int ps, int capEdge, bit capIrq, bit refIrq,
                                           bit restart, logic [1:0] src, bit en);
    return {16'd0, 8'(ps), 2'(capEdge), capIrq, refIrq, restart, src, en};
  endfunction

  function automatic int expPeriod(logic [1:0] src, int ps, int r);
    return ((src == SRC_SLOW) ? 16 : 1) * (ps + 1) * (r + 1);
  endfunction

  function automatic logic [31:0] expCount(int n, bit wide);
    return 32'(n) * (wide ? 32'd65537 : 32'd1);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdData;
  endtask

  task automatic setCap(logic v);
    @(negedge clk); capIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulseAck();
    @(negedge clk); dmaAck = 1'b1;
    @(negedge clk); dmaAck = 1'b0;
  endtask

  // enabled for m+2 counter ticks on the fast source with prescale 0
  task automatic runTicks(int m, bit restart, logic [31:0] extra);
    wr(A_MODE, modeWord(0, 0, 0, 0, restart, SRC_FAST, 1) | extra);
    repeat (m) @(negedge clk);
    wr(A_MODE, modeWord(0, 0, 0, 0, restart, SRC_FAST, 0) | extra);
  endtask

  task automatic measure(output int per);
    int c;
    do @(negedge clk); while (!refPulse);
    c = 0;
    do begin @(negedge clk); c++; end while (!refPulse);
    per = c;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual expired expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int per;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reg", v, 32'd0);
    end
    check("R1 irq", {31'd0, irqReq}, 32'd0);
    check("R1 dma", {31'd0, dmaReq}, 32'd0);
    check("R1 pulse", {31'd0, refPulse}, 32'd0);

    // R3 R2: random and corner periods in restart mode
    for (int i = 0; i < 9; i++) begin
      logic [1:0] src;
      int p, r;
      src = ($urandom % 2) ? SRC_SLOW : SRC_FAST;
      p = $urandom % 4;
      r = $urandom % 16;
      if (i == 6) begin src = SRC_FAST; p = 0;   r = 0; end
      if (i == 7) begin src = SRC_FAST; p = 255; r = 1; end
      if (i == 8) begin src = SRC_SLOW; p = 0;   r = 2; end
      wr(A_MODE, 32'd0);
      wr(A_COUNT, 32'd0);
      wr(A_REF, 32'(r));
      wr(A_MODE, modeWord(p, 0, 0, 0, 1, src, 1));
      measure(per);
      measure(per);
      check("R3 period", 32'(per), 32'(expPeriod(src, p, r)));
    end
    wr(A_MODE, 32'd0);
    wr(A_EVENT, 32'h3);

    // R5 R6 R7: random run lengths, both step sizes
    wr(A_REF, 32'hFFFF_FFFF);
    for (int i = 0; i < 6; i++) begin
      int m;
      bit wide;
      m = $urandom % 20;
      wide = (i < 2) ? bit'(i) : bit'($urandom % 2);
      wr(A_MODE, 32'd0);
      wr(A_XMODE, {31'd0, wide});
      wr(A_COUNT, $urandom);
      rd(A_COUNT, v);
      check("R7 write clears", v, 32'd0);
      runTicks(m, 0, 32'd0);
      rd(A_COUNT, v);
      check("R5 step count", v, expCount(m + 2, wide));
      repeat (5) @(negedge clk);
      rd(A_COUNT, v2);
      check("R6 hold when disabled", v2, v);
    end
    wr(A_XMODE, 32'd0);

    // R4 free-run passes the reference; R9 flag set with irq disabled
    wr(A_EVENT, 32'h3);
    wr(A_COUNT, 32'd0);
    wr(A_REF, 32'd3);
    runTicks(8, 0, 32'd0);
    rd(A_COUNT, v);
    check("R4 free run", v, 32'd10);
    rd(A_EVENT, v);
    check("R9 ref flag set", v, 32'h2);
    check("R10 irq masked", {31'd0, irqReq}, 32'd0);

    // R4 restart: 10 ticks with ref 3 leaves 10 mod 4
    wr(A_COUNT, 32'd0);
    runTicks(8, 1, 32'd0);
    rd(A_COUNT, v);
    check("R4 restart", v, 32'd2);

    // R9 R10 write-one-to-clear
    wr(A_MODE, modeWord(0, 0, 0, 1, 0, SRC_FAST, 0));
    wr(A_EVENT, 32'h0);
    rd(A_EVENT, v);
    check("R9 write zero keeps", v, 32'h2);
    check("R10 irq on", {31'd0, irqReq}, 32'd1);
    wr(A_EVENT, 32'h1);
    rd(A_EVENT, v);
    check("R9 other bit keeps", v, 32'h2);
    wr(A_EVENT, 32'h2);
    rd(A_EVENT, v);
    check("R9 cleared", v, 32'h0);
    check("R10 irq off", {31'd0, irqReq}, 32'd0);

    // R8 capture edges
    wr(A_MODE, 32'd0);
    wr(A_COUNT, 32'd0);
    wr(A_REF, 32'hFFFF_FFFF);
    runTicks(5, 0, 32'd0);
    wr(A_MODE, modeWord(0, 1, 1, 0, 0, SRC_FAST, 0));
    setCap(1'b1);
    rd(A_CAPT, v);
    check("R8 rising capture", v, 32'd7);
    rd(A_EVENT, v);
    check("R8 capture flag", v, 32'h1);
    check("R10 capture irq", {31'd0, irqReq}, 32'd1);
    wr(A_EVENT, 32'h1);
    wr(A_COUNT, 32'd0);
    setCap(1'b0);
    rd(A_EVENT, v);
    check("R8 falling ignored", v, 32'h0);
    rd(A_CAPT, v);
    check("R8 falling no latch", v, 32'd7);
    wr(A_MODE, modeWord(0, 2, 0, 0, 0, SRC_FAST, 0));
    setCap(1'b1);
    rd(A_CAPT, v);
    check("R8 rising ignored", v, 32'd7);
    wr(A_MODE, modeWord(0, 3, 0, 0, 0, SRC_FAST, 0));
    setCap(1'b0);
    rd(A_CAPT, v);
    check("R8 both edges", v, 32'd0);
    wr(A_CAPT, 32'hDEAD_BEEF);
    rd(A_CAPT, v);
    check("R8 read-only", v, 32'd0);

    // R11 DMA request and acknowledge
    wr(A_COUNT, 32'd0);
    wr(A_REF, 32'd0);
    runTicks(0, 0, modeWord(0, 3, 0, 0, 0, SRC_OFF, 0));
    setCap(1'b1);
    rd(A_EVENT, v);
    check("R9 both flags", v, 32'h3);
    check("R11 dma off", {31'd0, dmaReq}, 32'd0);
    pulseAck();
    rd(A_EVENT, v);
    check("R11 ack ignored", v, 32'h3);
    wr(A_XMODE, 32'h2);
    check("R11 dma on", {31'd0, dmaReq}, 32'd1);
    pulseAck();
    rd(A_EVENT, v);
    check("R11 ack clears", v, 32'h0);
    check("R11 dma drops", {31'd0, dmaReq}, 32'd0);
    wr(A_XMODE, 32'd0);

    // R2 external source and no source
    wr(A_MODE, 32'd0);
    wr(A_REF, 32'hFFFF_FFFF);
    for (int i = 0; i < 3; i++) begin
      int n;
      n = 3 + ($urandom % 6);
      wr(A_COUNT, 32'd0);
      wr(A_MODE, modeWord(0, 0, 0, 0, 0, SRC_EXT, 1));
      for (int k = 0; k < n; k++) begin
        @(negedge clk); extClkIn = 1'b1;
        repeat (3) @(negedge clk);
        extClkIn = 1'b0;
        repeat (3) @(negedge clk);
      end
      repeat (6) @(negedge clk);
      wr(A_MODE, 32'd0);
      rd(A_COUNT, v);
      check("R2 external count", v, 32'(n));
    end
    wr(A_COUNT, 32'd0);
    wr(A_MODE, modeWord(0, 0, 0, 0, 0, SRC_OFF, 1));
    repeat (20) @(negedge clk);
    rd(A_COUNT, v);
    check("R2 no source", v, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule